// File: doc/BRIEF.md
# Multi-Mode Integer Accumulate Lane

This block is one lane of an integer accumulate unit. Each accepted cycle it takes three 64-bit two's-complement operands `x`, `y` and `z`, a 6-bit operation code and a 5-bit shift count. It returns `z` plus or minus a shifted function of `x` and `y`. The function is a multiply or an add. There are also two special forms. One is a Q15 rounding multiply-high with 16-bit saturation. The other is an XNOR-popcount step for binary dot products. The caller sign-extends its operands to 64 bits before presenting them and truncates the 64-bit result to its own accumulator width. Operand fetch, lane iteration and write masking belong to the caller.

The datapath is split into two register stages. The first stage forms the product, the sum or the popcount. The second stage rounds, shifts, negates, accumulates and clamps. A new operation can be issued every cycle. Codes the lane does not implement pass `z` through unchanged and keep the valid flag low.

Top module: `lane_accum_alu`

## Requirements
- R1: Operation code 0 returns z + ((x*y) >>> s), with the product taken as the low 64 bits and `>>>` an arithmetic right shift by `shamt`.
- R2: Operation code 1 returns z - ((x*y) >>> s). The negation is applied to the already shifted product.
- R3: Operation code 2 returns z + ((x+y) >>> s), and code 3 returns z - ((x+y) >>> s).
- R4: The shift is arithmetic and rounds toward minus infinity. For example, -21 >>> 2 = -6.
- R5: Codes 5 and 6 add 2^14 to x*y and shift right by 15. Code 5 then adds the result to z, and code 6 subtracts it from z. The final value is clamped to [-32768, 32767].
- R6: In codes 5 and 6, only the low 16 bits of x, y and z are used, each sign-extended, and the `shamt` input is ignored.
- R7: Code 9 returns z + the number of one bits in (~(x ^ y)) << s over 64 bits. No further shift or negation is applied.
- R8: A result appears exactly two cycles after its input is sampled with `in_valid` high. Issue can happen every cycle. `out_valid` is high only for supported codes (0, 1, 2, 3, 5, 6, 9).
- R9: Any other code (for example 4, 7, 63) yields `result` equal to the z sampled with it, and `out_valid` stays low in that cycle.
- R10: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and code are presented this cycle |
| mode | input | 6 | Operation code |
| shamt | input | 5 | Right-shift count (or left shift of the XNOR word for code 9) |
| x | input | 64 | First operand, sign-extended |
| y | input | 64 | Second operand, sign-extended |
| z | input | 64 | Accumulator input, sign-extended |
| out_valid | output | 1 | Result of a supported operation is on `result` |
| result | output | 64 | Accumulated value |

## Verification
Several rules are checked by assertions on every cycle:
- the two-cycle relation between accepted inputs and `out_valid`;
- the pass-through of `z` for unsupported codes;
- the 16-bit clamp bounds of codes 5 and 6;
- the 0-to-64 range of the popcount increment.

The exact arithmetic can only be shown by the bench scenarios. This covers the floor behaviour of the arithmetic shift on negative products, the ordering of negation after the shift, the rounding constant, and the discarding of upper operand bits and `shamt` in the Q15 codes. It also covers the effect of the shift on the XNOR word.

// File: rtl/lacc_pkg.sv
// Package: shared control type and operation-code decode for the
// accumulate lane. Assumes a 6-bit operation code.
package lacc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_MAC  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_MSB  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_ADA  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_ADS  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_QRA  = 6'd5;
    localparam logic [OPC_W-1:0] OPC_QRS  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_XPC  = 6'd9;

    typedef struct packed {
        logic ok;       // code is implemented
        logic sel_add;  // f = x + y instead of x * y
        logic sel_pc;   // XNOR-popcount path
        logic neg;      // subtract term from z
        logic qmode;    // Q15 rounding, 16-bit operands, clamp
    } lacc_ctl_t;

    // Map an operation code to datapath controls; unknown codes clear ok.
    function automatic lacc_ctl_t lacc_decode_op(logic [OPC_W-1:0] code);
        lacc_ctl_t c;
        c = '0;
        unique case (code)
            OPC_MAC: begin c.ok = 1'b1; end
            OPC_MSB: begin c.ok = 1'b1; c.neg = 1'b1; end
            OPC_ADA: begin c.ok = 1'b1; c.sel_add = 1'b1; end
            OPC_ADS: begin c.ok = 1'b1; c.sel_add = 1'b1; c.neg = 1'b1; end
            OPC_QRA: begin c.ok = 1'b1; c.qmode = 1'b1; end
            OPC_QRS: begin c.ok = 1'b1; c.qmode = 1'b1; c.neg = 1'b1; end
            OPC_XPC: begin c.ok = 1'b1; c.sel_pc = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lacc_decode.sv
// Module: operation-code decoder. Purely combinational; assumes the
// code is stable while in_valid is high.
module lacc_decode
    import lacc_pkg::*;
(
    input  logic [OPC_W-1:0] code,
    output lacc_ctl_t        ctl
);

    // Translate the code into per-stage control bits.
    always_comb begin
        ctl = lacc_decode_op(code);
    end

endmodule

// File: rtl/lacc_popcnt.sv
// Module: population count of a W-bit word as a two-level tree:
// nibble counts built by generate, then summed. Assumes W % 4 == 0.
module lacc_popcnt #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1),
    localparam int NIB = W / 4
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);

    logic [2:0] nib_cnt [NIB];

    for (genvar g = 0; g < NIB; g++) begin : g_nib
        // Count the one bits in one nibble.
        assign nib_cnt[g] = {2'b00, word[4*g]}   + {2'b00, word[4*g+1]}
                          + {2'b00, word[4*g+2]} + {2'b00, word[4*g+3]};
    end

    // Sum the nibble counts into the full count.
    always_comb begin
        count = '0;
        for (int i = 0; i < NIB; i++) begin
            count = count + CW'(nib_cnt[i]);
        end
    end

endmodule

// File: rtl/lacc_front.sv
// Module: first datapath stage. Selects the operand view (full width or
// low SAT_W bits sign-extended), and forms the product, the sum or the
// XNOR popcount. Also chooses the effective shift and accumulator.
// Assumes SAT_W < DATA_W and Q_SHIFT < 2**SH_W.
module lacc_front #(
    parameter int DATA_W  = 64,
    parameter int SH_W    = 5,
    parameter int SAT_W   = 16,
    parameter int Q_SHIFT = 15,
    localparam int PC_W   = $clog2(DATA_W + 1)
) (
    input  logic              sel_add,
    input  logic              sel_pc,
    input  logic              qmode,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [DATA_W-1:0] z,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] z_eff,
    output logic [SH_W-1:0]   sh_eff
);

    logic [DATA_W-1:0] xa, ya;
    logic [DATA_W-1:0] prod, sum;
    logic [DATA_W-1:0] xn_word;
    logic [PC_W-1:0]   pc;

    // Operand view: narrow Q15 operands are re-extended from their low bits.
    always_comb begin
        if (qmode) begin
            xa    = {{(DATA_W-SAT_W){x[SAT_W-1]}}, x[SAT_W-1:0]};
            ya    = {{(DATA_W-SAT_W){y[SAT_W-1]}}, y[SAT_W-1:0]};
            z_eff = {{(DATA_W-SAT_W){z[SAT_W-1]}}, z[SAT_W-1:0]};
        end else begin
            xa    = x;
            ya    = y;
            z_eff = z;
        end
    end

    // Effective shift: fixed for Q15 codes, caller's count otherwise.
    always_comb begin
        sh_eff = qmode ? SH_W'(Q_SHIFT) : shamt;
    end

    // Arithmetic kernels: low half of product, plain sum, XNOR word.
    always_comb begin
        prod    = xa * ya;
        sum     = xa + ya;
        xn_word = (~(x ^ y)) << shamt;
    end

    lacc_popcnt #(.W(DATA_W)) u_popcnt (
        .word  (xn_word),
        .count (pc)
    );

    // Pick the kernel output carried to the second stage.
    always_comb begin
        if (sel_pc)       raw = DATA_W'(pc);
        else if (sel_add) raw = sum;
        else              raw = prod;
    end

endmodule

// File: rtl/lacc_back.sv
// Module: second datapath stage. Rounds (Q15 only), shifts arithmetically,
// negates, accumulates and clamps (Q15 only). Unsupported codes return
// the accumulator input. Assumes Q_SHIFT >= 1.
module lacc_back
    import lacc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SH_W    = 5,
    parameter int SAT_W   = 16,
    parameter int Q_SHIFT = 15
) (
    input  lacc_ctl_t         ctl,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] z_eff,
    input  logic [SH_W-1:0]   sh_eff,
    output logic [DATA_W-1:0] res
);

    localparam logic [DATA_W-1:0] RND_K  = DATA_W'(1) << (Q_SHIFT - 1);
    localparam logic signed [DATA_W-1:0] SAT_HI = (DATA_W'(1) << (SAT_W - 1)) - DATA_W'(1);
    localparam logic signed [DATA_W-1:0] SAT_LO = ~SAT_HI;

    logic [DATA_W-1:0]        rounded;
    logic [DATA_W-1:0]        shifted;
    logic [DATA_W-1:0]        term;
    logic signed [DATA_W-1:0] acc;
    logic [DATA_W-1:0]        clamped;

    // Add the half-LSB constant ahead of the shift for Q15 codes.
    always_comb begin
        rounded = ctl.qmode ? raw + RND_K : raw;
    end

    // Arithmetic shift; popcount bypasses it.
    always_comb begin
        shifted = ctl.sel_pc ? raw : DATA_W'($signed(rounded) >>> sh_eff);
    end

    // Negate after the shift, then accumulate.
    always_comb begin
        term = ctl.neg ? (~shifted + DATA_W'(1)) : shifted;
        acc  = $signed(z_eff + term);
    end

    // Clamp into the signed SAT_W range for Q15 codes.
    always_comb begin
        if (ctl.qmode && (acc > SAT_HI))      clamped = SAT_HI;
        else if (ctl.qmode && (acc < SAT_LO)) clamped = SAT_LO;
        else                                  clamped = acc;
    end

    // Unsupported codes hand the accumulator back untouched.
    always_comb begin
        res = ctl.ok ? clamped : z_eff;
    end

endmodule

// File: rtl/lane_accum_alu.sv
// Module: top of the accumulate lane. Two register stages: kernel
// results are registered, then the accumulated value. Latency is two
// cycles, issue rate one per cycle. Synchronous active-low reset.
module lane_accum_alu
    import lacc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SH_W    = 5,
    parameter int SAT_W   = 16,
    parameter int Q_SHIFT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  mode,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [DATA_W-1:0] z,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    lacc_ctl_t         ctl_d, s1_ctl;
    logic [DATA_W-1:0] raw_d, zef_d, s1_raw, s1_z, res_d;
    logic [SH_W-1:0]   sh_d, s1_sh;
    logic              s1_vld;

    lacc_decode u_dec (
        .code (mode),
        .ctl  (ctl_d)
    );

    lacc_front #(
        .DATA_W(DATA_W), .SH_W(SH_W), .SAT_W(SAT_W), .Q_SHIFT(Q_SHIFT)
    ) u_front (
        .sel_add (ctl_d.sel_add),
        .sel_pc  (ctl_d.sel_pc),
        .qmode   (ctl_d.qmode),
        .shamt   (shamt),
        .x       (x),
        .y       (y),
        .z       (z),
        .raw     (raw_d),
        .z_eff   (zef_d),
        .sh_eff  (sh_d)
    );

    // Stage-1 register: kernel result, accumulator view and controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_ctl <= '0;
            s1_raw <= '0;
            s1_z   <= '0;
            s1_sh  <= '0;
        end else begin
            s1_vld <= in_valid;
            s1_ctl <= ctl_d;
            s1_raw <= raw_d;
            s1_z   <= zef_d;
            s1_sh  <= sh_d;
        end
    end

    lacc_back #(
        .DATA_W(DATA_W), .SH_W(SH_W), .SAT_W(SAT_W), .Q_SHIFT(Q_SHIFT)
    ) u_back (
        .ctl    (s1_ctl),
        .raw    (s1_raw),
        .z_eff  (s1_z),
        .sh_eff (s1_sh),
        .res    (res_d)
    );

    // Stage-2 register: accumulated value and qualified valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_vld & s1_ctl.ok;
            result    <= res_d;
        end
    end

endmodule

// File: rtl/lacc_chk.sv
// Module: assertion checker for the accumulate lane, bound to the top.
// Uses a small cycles-since-reset counter so nothing reaches into reset.
module lacc_chk
    import lacc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  mode,
    input logic [DATA_W-1:0] z,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    logic [1:0] up_cnt;

    // Count clean cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)            up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R8: valid follows an accepted supported code by exactly two cycles.
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |->
            (out_valid == ($past(in_valid, 2) && lacc_decode_op($past(mode, 2)).ok)));

    // R9: unsupported code hands back z with valid low.
    a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_cnt >= 2'd2) && $past(in_valid, 2) && !lacc_decode_op($past(mode, 2)).ok)
            |-> (!out_valid && (result == $past(z, 2))));

    // R5: Q15 codes stay inside the signed 16-bit range.
    a_r5_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (up_cnt >= 2'd2) && lacc_decode_op($past(mode, 2)).qmode)
            |-> (($signed(result) <= 64'sd32767) && ($signed(result) >= -64'sd32768)));

    // R7: popcount step adds between 0 and DATA_W to z.
    a_r7_pc_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (up_cnt >= 2'd2) && lacc_decode_op($past(mode, 2)).sel_pc)
            |-> ((result - $past(z, 2)) <= DATA_W'(DATA_W)));

    // R10: reset clears the valid flag.
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd1) |-> !out_valid);

endmodule

bind lane_accum_alu lacc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .z         (z),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_accum_alu_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops
// and compares them two cycles after each accepted input.
module lane_accum_alu_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        v;
        logic [63:0] r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  mode = '0;
    logic [4:0]  shamt = '0;
    logic [63:0] x = '0, y = '0, z = '0;
    logic        out_valid;
    logic [63:0] result;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic [1:0] acc_pipe = 2'b00;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_accum_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .shamt(shamt), .x(x), .y(y), .z(z),
        .out_valid(out_valid), .result(result)
    );

    // Expected value from the requirement text.
    function automatic exp_t model(logic [5:0] m, logic [4:0] s,
                                   longint xv, longint yv, longint zv, string tag);
        exp_t e;
        longint t, xs, ys, zs;
        e.v = 1'b1; e.tag = tag;
        case (m)
            6'd0: e.r = zv + ((xv * yv) >>> s);
            6'd1: e.r = zv - ((xv * yv) >>> s);
            6'd2: e.r = zv + ((xv + yv) >>> s);
            6'd3: e.r = zv - ((xv + yv) >>> s);
            6'd5, 6'd6: begin
                xs = longint'(shortint'(xv[15:0]));
                ys = longint'(shortint'(yv[15:0]));
                zs = longint'(shortint'(zv[15:0]));
                t  = (xs * ys + 64'sd16384) >>> 15;
                t  = (m == 6'd5) ? zs + t : zs - t;
                if (t > 32767)  t = 32767;
                if (t < -32768) t = -32768;
                e.r = t;
            end
            6'd9: e.r = zv + longint'($countones((~(xv ^ yv)) << s));
            default: begin e.v = 1'b0; e.r = zv; end
        endcase
        return e;
    endfunction

    // Drive one operation and queue the given expectation.
    task automatic issue(logic [5:0] m, logic [4:0] s, logic [63:0] xv,
                         logic [63:0] yv, logic [63:0] zv, exp_t e);
        @(posedge clk); #1;
        in_valid = 1'b1; mode = m; shamt = s; x = xv; y = yv; z = zv;
        exp_q.push_back(e);
    endtask

    task automatic send(logic [5:0] m, logic [4:0] s, logic [63:0] xv,
                        logic [63:0] yv, logic [63:0] zv, string tag);
        issue(m, s, xv, yv, zv, model(m, s, xv, yv, zv, tag));
    endtask

    task automatic send_lit(logic [5:0] m, logic [4:0] s, logic [63:0] xv,
                            logic [63:0] yv, logic [63:0] zv,
                            logic ev, logic [63:0] er, string tag);
        exp_t e;
        e.v = ev; e.r = er; e.tag = tag;
        issue(m, s, xv, yv, zv, e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0;
        mode = 6'd0; x = $urandom; y = $urandom; z = $urandom;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Track accepted inputs through the two-cycle latency.
    always @(posedge clk) begin
        if (!rst_n) acc_pipe <= 2'b00;
        else        acc_pipe <= {acc_pipe[0], in_valid};
    end

    // Monitor: compare the matured item away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && acc_pipe[1]) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected output", {63'd0, out_valid}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " valid"}, {63'd0, out_valid}, {63'd0, e.v});
                chk({e.tag, " result"}, result, e.r);
            end
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R10 reset result", result, 64'd0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R1/R2/R4: negative product, floor shift, negate after shift.
        send_lit(6'd0, 5'd2, -64'sd7, 64'sd3, 64'sd100, 1'b1, 64'sd94, "R1 R4 mac floor");
        send_lit(6'd1, 5'd2, -64'sd7, 64'sd3, 64'sd100, 1'b1, 64'sd106, "R2 msub after shift");
        send(6'd0, 5'd0, 64'd123456789, 64'd987, -64'sd5, "R1 mac s0");
        send(6'd1, 5'd31, 64'h7fff_ffff, 64'h7fff_ffff, 64'd1, "R2 msub s31");
        // R3: add forms.
        send_lit(6'd2, 5'd1, -64'sd5, 64'sd2, 64'sd10, 1'b1, 64'sd8, "R3 add floor");
        send_lit(6'd3, 5'd1, -64'sd5, 64'sd2, 64'sd10, 1'b1, 64'sd12, "R3 sub");
        send(6'd2, 5'd4, 64'h7fff_ffff_ffff_ffff, 64'd1, 64'd0, "R3 add wrap");
        // R5: rounding and clamp.
        send_lit(6'd5, 5'd0, 64'sd3, 64'sd16384, 64'sd10, 1'b1, 64'sd12, "R5 round");
        send_lit(6'd5, 5'd0, -64'sd32768, -64'sd32768, 64'sd0, 1'b1, 64'sd32767, "R5 clamp hi");
        send_lit(6'd6, 5'd0, -64'sd32768, -64'sd32768, 64'sd0, 1'b1, -64'sd32768, "R5 edge lo");
        send_lit(6'd6, 5'd0, -64'sd32768, -64'sd32768, -64'sd100, 1'b1, -64'sd32768, "R5 clamp lo");
        // R6: upper bits and shamt ignored in Q15 codes.
        send_lit(6'd5, 5'd7, 64'hffff_0000_0000_0003, 64'h0001_0000_0000_4000,
                 64'h1234_0000_0000_000a, 1'b1, 64'sd12, "R6 narrow view");
        // R7: popcount of shifted XNOR word.
        send_lit(6'd9, 5'd0, 64'd0, 64'd0, 64'd5, 1'b1, 64'd69, "R7 pc all");
        send_lit(6'd9, 5'd4, 64'd0, 64'd0, 64'd5, 1'b1, 64'd65, "R7 pc shift");
        send_lit(6'd9, 5'd0, 64'd0, '1, 64'd5, 1'b1, 64'd5, "R7 pc none");
        // R9: unsupported codes.
        send_lit(6'd4, 5'd3, 64'd9, 64'd9, 64'hdead, 1'b0, 64'hdead, "R9 code4");
        send_lit(6'd7, 5'd0, 64'd1, 64'd1, 64'h1234_5678_9abc_def0, 1'b0,
                 64'h1234_5678_9abc_def0, "R9 code7");
        send_lit(6'd63, 5'd0, 64'd1, 64'd1, 64'd77, 1'b0, 64'd77, "R9 code63");
        idle();
        idle();
        // R8: bubbles mixed with back-to-back issue.
        for (int i = 0; i < 300; i++) begin
            logic [5:0] m;
            m = 6'($urandom_range(0, 10));
            if ($urandom_range(0, 3) == 0) idle();
            else send(m, 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                      {$urandom, $urandom}, "R8 stream");
        end
        idle();
        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) chk("R8 drain", 64'(exp_q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", exp_q.size());
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule